// File: doc/BRIEF.md
# Cascadable Compare Timer with Output Modulator

This block is a compare timer made of a narrow low stage (4 bits by default) and a wide high stage (8 bits by default). In cascade mode the two stages form a single 12-bit up-counter that is checked against the joined compare value. In prescaler mode the low stage divides the count rate of the high stage, and the compare event comes from the high stage alone. Every compare event can reset the counter, raise a one-cycle interrupt and emit a tick for a serial shifter.

The output pin is driven by a modulator. It has four modes: a toggling flip-flop, a burst gate over a fixed-ratio duty-cycle generator, a Manchester encoder of a serial data bit, and a PWM comparator. The clock source and the register access path are outside this block. The counter advances on every clock while `run` is high. It is held at zero while `run` is low.

Top module: `cascade_cmp_timer`

## Requirements
- R1: With `cntMode`=0 (cascade) and `clrOnMatch`=1, a match occurs on a running clock edge where the 12-bit count equals {cmpHi,cmpLo}, and the count then restarts at zero. The first match comes on the (N+1)th running edge after start, and matches repeat every N+1 edges, where N is the joined compare value.
- R2: With `cntMode`=1 (prescaler), the low stage advances every running edge and restarts when it equals cmpLo. The high stage advances on each such restart, and a match occurs when the high stage equals cmpHi on a restart edge. Matches repeat every (cmpLo+1)*(cmpHi+1) edges.
- R3: In prescaler mode with cmpLo=0, the high stage advances on every running edge, so matches repeat every cmpHi+1 edges.
- R4: With `outMode`=0 (toggle), `timerOut` follows an output flip-flop that inverts on every match.
- R5: When `toggleOnStart`=1, the output flip-flop inverts on the first running edge after `run` rises. If a toggle-mode match falls on that same edge, the two inversions cancel.
- R6: The duty-cycle generator advances one phase per match, modulo M. M is 2, 3 or 4 for `dutySel`=0, 1 or 2, and `dutySel`=3 acts as 2. Its output is high only in phase 0, and the phase restarts at 0 on the start edge.
- R7: With `outMode`=1 (burst), `timerOut` is the duty-cycle generator output ANDed with the output flip-flop. Matches do not invert the flip-flop in this mode.
- R8: With `outMode`=2 (Manchester), a half-bit lasts one match interval. `serData` is captured on the start edge and again on every second match after it; values on other edges are ignored. The output is the bit in the first half and its inverse in the second half, so a one falls mid-bit and a zero rises mid-bit.
- R9: With `outMode`=3 (PWM), `clrOnMatch` is ignored and the counter free-runs. `timerOut` is high while running and the count is below the compare: the 12-bit joined value in cascade mode, or cmpHi against the high stage in prescaler mode.
- R10: In the cycle after each matching edge, `baudTick` pulses for one cycle. `matchIrq` pulses in that same cycle only when `irqMask` was 1.
- R11: With `clrOnMatch`=0 outside PWM mode, the count wraps through 4095, so the next match comes 4096 edges after the previous one.
- R12: After reset, `timerOut`, `matchIrq` and `baudTick` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; rising level starts a run, low holds counter at zero |
| cntMode | input | 1 | 0 cascade 12-bit, 1 low stage as prescaler |
| outMode | input | 2 | 0 toggle, 1 burst, 2 Manchester, 3 PWM |
| dutySel | input | 2 | Duty-cycle generator ratio select |
| cmpLo | input | LO_W | Low-stage compare value |
| cmpHi | input | HI_W | High-stage compare value |
| clrOnMatch | input | 1 | Restart counter on match |
| irqMask | input | 1 | Enables `matchIrq` |
| toggleOnStart | input | 1 | Invert output flip-flop on start edge |
| serData | input | 1 | Serial bit for Manchester encoding |
| timerOut | output | 1 | Modulated timer output |
| matchIrq | output | 1 | One-cycle compare interrupt |
| baudTick | output | 1 | One-cycle tick per match |

## Verification
The start-edge inversion and a toggle-mode match can land on the same clock edge. The bench provokes this with a joined compare value of zero while `toggleOnStart` is set, so the counter matches on the very edge that starts the run. It then checks that the output stays low after that edge, that the interrupt still pulses, and that the output alternates on each following edge. In the Manchester test, the start edge carries a match-free capture. The serial input is driven to the wrong value on every edge that must not capture, and the output pattern shows whether any such value leaked in.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    OM_TOGGLE = 2'd0,
    OM_BURST  = 2'd1,
    OM_MANCH  = 2'd2,
    OM_PWM    = 2'd3
  } outMode_e;

  // Strobes from the control to the counter datapath and modulator
  typedef struct packed {
    logic hold;     // counter forced to zero
    logic advance;  // counter steps this edge
    logic clrEn;    // match restarts the counter
    logic startEv;  // first running edge
    logic matchEv;  // qualified compare event
  } strobes_t;

endpackage

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic            preMode,
  input  logic [LO_W-1:0] cmpLo,
  input  logic [HI_W-1:0] cmpHi,
  output logic            matchHit,
  output logic            pwmLevel
);

  localparam int CNT_W = LO_W + HI_W;

  logic [LO_W-1:0]  loCnt;
  logic [HI_W-1:0]  hiCnt;
  logic [CNT_W-1:0] fullCnt;
  logic [CNT_W-1:0] fullCmp;
  logic             preTick;

  assign fullCnt = {hiCnt, loCnt};
  assign fullCmp = {cmpHi, cmpLo};
  // A zero low compare makes preTick true on every edge: bypass for free
  assign preTick = (loCnt == cmpLo);

  always_comb begin
    if (preMode) begin
      matchHit = preTick && (hiCnt == cmpHi);
      pwmLevel = stb.advance && (hiCnt < cmpHi);
    end else begin
      matchHit = (fullCnt == fullCmp);
      pwmLevel = stb.advance && (fullCnt < fullCmp);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loCnt <= '0;
      hiCnt <= '0;
    end else if (stb.hold) begin
      loCnt <= '0;
      hiCnt <= '0;
    end else if (stb.advance) begin
      if (preMode) begin
        if (preTick) begin
          loCnt <= '0;
          hiCnt <= (matchHit && stb.clrEn) ? '0 : hiCnt + 1'b1;
        end else begin
          loCnt <= loCnt + 1'b1;
        end
      end else begin
        if (matchHit && stb.clrEn) {hiCnt, loCnt} <= '0;
        else                       {hiCnt, loCnt} <= fullCnt + 1'b1;
      end
    end
  end

  // R1 / R2: a clearing match leaves both stages at zero
  a_r1_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.advance && matchHit && stb.clrEn) |-> (fullCnt == '0));

  // R9: a stopped timer always restarts from zero
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.hold) |-> (fullCnt == '0));

endmodule

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     run,
  input  outMode_e outMode,
  input  logic     clrOnMatch,
  input  logic     irqMask,
  input  logic     matchHit,
  output strobes_t stb,
  output logic     matchIrq,
  output logic     baudTick
);

  logic runQ;

  always_comb begin
    stb.hold    = !run;
    stb.advance = run;
    stb.clrEn   = clrOnMatch && (outMode != OM_PWM);
    stb.startEv = run && !runQ;
    stb.matchEv = run && matchHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      matchIrq <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      runQ     <= run;
      matchIrq <= stb.matchEv && irqMask;
      baudTick <= stb.matchEv;
    end
  end

  // R10: a masked edge never yields an interrupt
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(irqMask) |-> !matchIrq);

  // R10: every interrupt pulse coincides with a tick
  a_r10_irq_with_tick: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |-> baudTick);

endmodule

// File: rtl/cct_modulator.sv
module cct_modulator
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   stb,
  input  outMode_e   outMode,
  input  logic [1:0] dutySel,
  input  logic       toggleOnStart,
  input  logic       serData,
  input  logic       pwmLevel,
  output logic       timerOut
);

  logic       outFf;
  logic [1:0] dcgPhase;
  logic [1:0] dcgLast;
  logic       halfSel;
  logic       bitReg;
  logic       startFlip;
  logic       matchFlip;

  always_comb begin
    case (dutySel)
      2'd1:    dcgLast = 2'd2;  // one third
      2'd2:    dcgLast = 2'd3;  // one quarter
      default: dcgLast = 2'd1;  // half
    endcase
  end

  assign startFlip = stb.startEv && toggleOnStart;
  assign matchFlip = stb.matchEv && (outMode == OM_TOGGLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outFf <= 1'b0;
    else       outFf <= outFf ^ startFlip ^ matchFlip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcgPhase <= '0;
    end else if (stb.startEv) begin
      dcgPhase <= '0;
    end else if (stb.matchEv) begin
      dcgPhase <= (dcgPhase >= dcgLast) ? 2'd0 : dcgPhase + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfSel <= 1'b0;
      bitReg  <= 1'b0;
    end else if (stb.startEv) begin
      halfSel <= 1'b0;
      bitReg  <= serData;
    end else if (stb.matchEv) begin
      halfSel <= !halfSel;
      if (halfSel) bitReg <= serData;
    end
  end

  always_comb begin
    case (outMode)
      OM_TOGGLE: timerOut = outFf;
      OM_BURST:  timerOut = outFf && (dcgPhase == 2'd0);
      OM_MANCH:  timerOut = bitReg ^ halfSel;
      default:   timerOut = pwmLevel;
    endcase
  end

  // R5: a lone start flip inverts the flip-flop
  a_r5_start_flip: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(startFlip && !matchFlip) |-> (outFf != $past(outFf)));

  // R6: the generator phase only moves on a match or a start
  a_r6_phase_still: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(!stb.startEv && !stb.matchEv) |-> $stable(dcgPhase));

  // R8: each match inside a run swaps the half-bit
  a_r8_half_swap: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.matchEv && !stb.startEv) |-> (halfSel != $past(halfSel)));

endmodule

// File: rtl/cascade_cmp_timer.sv
module cascade_cmp_timer
  import cct_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic            cntMode,
  input  logic [1:0]      outMode,
  input  logic [1:0]      dutySel,
  input  logic [LO_W-1:0] cmpLo,
  input  logic [HI_W-1:0] cmpHi,
  input  logic            clrOnMatch,
  input  logic            irqMask,
  input  logic            toggleOnStart,
  input  logic            serData,
  output logic            timerOut,
  output logic            matchIrq,
  output logic            baudTick
);

  strobes_t stb;
  outMode_e modeSel;
  logic     matchHit;
  logic     pwmLevel;

  assign modeSel = outMode_e'(outMode);

  cct_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .outMode    (modeSel),
    .clrOnMatch (clrOnMatch),
    .irqMask    (irqMask),
    .matchHit   (matchHit),
    .stb        (stb),
    .matchIrq   (matchIrq),
    .baudTick   (baudTick)
  );

  cct_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_counter (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .preMode  (cntMode),
    .cmpLo    (cmpLo),
    .cmpHi    (cmpHi),
    .matchHit (matchHit),
    .pwmLevel (pwmLevel)
  );

  cct_modulator u_mod (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .outMode       (modeSel),
    .dutySel       (dutySel),
    .toggleOnStart (toggleOnStart),
    .serData       (serData),
    .pwmLevel      (pwmLevel),
    .timerOut      (timerOut)
  );

endmodule

// File: tb/tb_cascade_cmp_timer.sv
module tb_cascade_cmp_timer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       run;
  logic       cntMode;
  logic [1:0] outMode;
  logic [1:0] dutySel;
  logic [3:0] cmpLo;
  logic [7:0] cmpHi;
  logic       clrOnMatch;
  logic       irqMask;
  logic       toggleOnStart;
  logic       serData;
  logic       timerOut;
  logic       matchIrq;
  logic       baudTick;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  cascade_cmp_timer dut (
    .clk(clk), .rstN(rstN), .run(run), .cntMode(cntMode), .outMode(outMode),
    .dutySel(dutySel), .cmpLo(cmpLo), .cmpHi(cmpHi), .clrOnMatch(clrOnMatch),
    .irqMask(irqMask), .toggleOnStart(toggleOnStart), .serData(serData),
    .timerOut(timerOut), .matchIrq(matchIrq), .baudTick(baudTick)
  );

  task automatic check(input string req, input string what, input int act, input int expv);
    testCnt++;
    if (act != expv) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic doReset();
    run = 0; cntMode = 0; outMode = 0; dutySel = 0; cmpLo = 0; cmpHi = 0;
    clrOnMatch = 1; irqMask = 1; toggleOnStart = 0; serData = 0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    check("R12", "timerOut", int'(timerOut), 0);
    check("R12", "matchIrq", int'(matchIrq), 0);
    check("R12", "baudTick", int'(baudTick), 0);
  endtask

  // R1, R4, R10: joined compare 0x012 gives a period of 19 edges
  task automatic t_cascade();
    doReset();
    cmpHi = 8'h01; cmpLo = 4'h2;
    run = 1;
    for (int c = 0; c < 45; c++) begin
      @(negedge clk);
      check("R1", $sformatf("baudTick c=%0d", c), int'(baudTick), int'((c + 1) % 19 == 0));
      check("R10", $sformatf("matchIrq c=%0d", c), int'(matchIrq), int'((c + 1) % 19 == 0));
      check("R4", $sformatf("timerOut c=%0d", c), int'(timerOut), ((c + 1) / 19) % 2);
    end
  endtask

  // R10: mask suppresses the interrupt but not the tick
  task automatic t_mask();
    doReset();
    cmpLo = 4'd5; irqMask = 0;
    run = 1;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      check("R10", $sformatf("masked matchIrq c=%0d", c), int'(matchIrq), 0);
      check("R10", $sformatf("baudTick c=%0d", c), int'(baudTick), int'((c + 1) % 6 == 0));
    end
  endtask

  // R2: prescaler 2, high compare 3 gives 12 edges
  task automatic t_prescale();
    doReset();
    cntMode = 1; cmpLo = 4'd2; cmpHi = 8'd3;
    run = 1;
    for (int c = 0; c < 26; c++) begin
      @(negedge clk);
      check("R2", $sformatf("baudTick c=%0d", c), int'(baudTick), int'((c + 1) % 12 == 0));
      check("R2", $sformatf("timerOut c=%0d", c), int'(timerOut), ((c + 1) / 12) % 2);
    end
  endtask

  // R3: low compare zero bypasses the prescaler
  task automatic t_bypass();
    doReset();
    cntMode = 1; cmpLo = 4'd0; cmpHi = 8'd4;
    run = 1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check("R3", $sformatf("baudTick c=%0d", c), int'(baudTick), int'((c + 1) % 5 == 0));
    end
  endtask

  // R11: no clear, the count wraps the full 12-bit range
  task automatic t_wrap();
    doReset();
    clrOnMatch = 0; cmpLo = 4'd3;
    run = 1;
    for (int c = 0; c < 4102; c++) begin
      @(negedge clk);
      check("R11", $sformatf("baudTick c=%0d", c), int'(baudTick), int'(c == 3 || c == 4099));
    end
  endtask

  // R5: start flip, then start flip colliding with a match
  task automatic t_start();
    doReset();
    toggleOnStart = 1; cmpLo = 4'd3;
    run = 1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check("R5", $sformatf("timerOut c=%0d", c), int'(timerOut), (1 + (c + 1) / 4) % 2);
    end
    doReset();
    toggleOnStart = 1; cmpLo = 4'd0; cmpHi = 8'd0;
    run = 1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check("R5", $sformatf("collide timerOut c=%0d", c), int'(timerOut), c % 2);
      check("R10", $sformatf("collide matchIrq c=%0d", c), int'(matchIrq), 1);
    end
  endtask

  // R6, R7: burst gating over every duty select
  task automatic t_burst();
    for (int d = 0; d < 4; d++) begin
      int m;
      m = (d == 1) ? 3 : (d == 2) ? 4 : 2;
      doReset();
      outMode = 2'd1; dutySel = 2'(d); toggleOnStart = 1; cmpLo = 4'd1;
      run = 1;
      for (int c = 0; c < 18; c++) begin
        @(negedge clk);
        check("R6", $sformatf("duty%0d timerOut c=%0d", d, c), int'(timerOut),
              int'((((c + 1) / 2) % m) == 0));
      end
    end
    doReset();
    outMode = 2'd1; dutySel = 2'd0; toggleOnStart = 0; cmpLo = 4'd1;
    run = 1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check("R7", $sformatf("gated timerOut c=%0d", c), int'(timerOut), 0);
    end
  endtask

  // R8: Manchester, wrong data driven on every non-capture edge
  task automatic t_manch();
    logic [3:0] bits;
    bits = 4'b1001;
    doReset();
    outMode = 2'd2; cmpLo = 4'd2;
    run = 1;
    for (int c = 0; c < 23; c++) begin
      int k;
      bit cap;
      cap = (c == 0) || ((c + 1) % 6 == 0);
      serData = cap ? bits[(c + 1) / 6] : ~bits[(c + 1) / 6];
      @(negedge clk);
      k = (c + 1) / 3;
      check("R8", $sformatf("timerOut c=%0d", c), int'(timerOut), int'(bits[k / 2] ^ (k % 2)));
    end
  endtask

  // R9: PWM in both counter modes, clear ignored
  task automatic t_pwm();
    doReset();
    outMode = 2'd3; cmpLo = 4'd3;
    @(negedge clk);
    check("R9", "idle timerOut", int'(timerOut), 0);
    run = 1;
    for (int c = 0; c < 4101; c++) begin
      @(negedge clk);
      check("R9", $sformatf("timerOut c=%0d", c), int'(timerOut), int'(((c + 1) % 4096) < 3));
      check("R9", $sformatf("baudTick c=%0d", c), int'(baudTick), int'(c == 3 || c == 4099));
    end
    doReset();
    outMode = 2'd3; cntMode = 1; cmpLo = 4'd0; cmpHi = 8'd2;
    run = 1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      check("R9", $sformatf("8-bit timerOut c=%0d", c), int'(timerOut), int'(((c + 1) % 256) < 2));
    end
  endtask

  initial begin
    t_reset();
    t_cascade();
    t_mask();
    t_prescale();
    t_bypass();
    t_wrap();
    t_start();
    t_burst();
    t_manch();
    t_pwm();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule